// File: doc/BRIEF.md
# Cascadable Pulse Accumulator

This block counts activity seen on a timer input pin. It holds two 8-bit counters. While its system enable is clear, the two counters are separate: each one counts single-cycle strobes from its own capture edge detector, but only when its own enable bit is set. While the system enable is set, the two counters act as the low and high bytes of one 16-bit accumulator. That accumulator runs on its own, whether or not the rest of the timer is running.

The 16-bit accumulator has two modes. In event mode it counts one selected edge of the synchronised pin. In gated mode it counts ticks of an external prescaler enable for as long as the pin sits at its active level. The pin passes through a two-flop synchroniser. The synchronised level is also sent out, so that the capture channel sharing the pin can use it. The block has an overflow flag and an edge flag, each with its own interrupt output. Software reaches the control bits, the flags and both counter bytes through a simple register port: synchronous writes and a combinational read.

Register map, by 2-bit address: 0 = control, 1 = flags, 2 = counter low byte, 3 = counter high byte. Control bits are: bit 0 system enable, bit 1 gated mode, bit 2 edge/level select, bit 3 overflow interrupt enable, bit 4 edge interrupt enable, bit 5 low-byte enable, bit 6 high-byte enable. Bit 7 reads as 0. Flags are: bit 0 overflow, bit 1 edge.

Top module: `pulse_accum_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, both interrupt outputs are low and `pin_sync` is low.
- R2: `pin_sync` equals `pin_in` delayed by two clock edges. A counted pin edge changes the counter on the third edge after `pin_in` is driven.
- R3: With control bit 0 = 1 and bit 1 = 0, the 16-bit value {address 3, address 2} goes up by one for each rising edge of `pin_sync` when bit 2 = 1, or for each falling edge when bit 2 = 0. A carry moves from the low byte into the high byte.
- R4: With control bits 0 and 1 set, the 16-bit value goes up by one on each cycle where `tick` is high and `pin_sync` equals control bit 2.
- R5: With control bit 0 = 0, the low byte counts `lo_evt` cycles only while control bit 5 is 1, and the high byte counts `hi_evt` cycles only while control bit 6 is 1. There is no carry between the bytes.
- R6: With control bit 0 = 1, control bits 5 and 6 and the strobes `lo_evt` and `hi_evt` have no effect on the count.
- R7: A 16-bit step from 0xFFFF to 0x0000 sets flag bit 0. `ovf_irq` is high while flag bit 0 and control bit 3 are both 1.
- R8: With control bit 0 = 1, flag bit 1 is set by the counted edge in event mode, or by the edge that ends the active level in gated mode. It is never set while control bit 0 = 0. `edge_irq` is high while flag bit 1 and control bit 4 are both 1.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A set in the same cycle wins over the clear.
- R10: A write to address 2 or 3 loads that byte. In 16-bit mode a byte write cancels that cycle's increment of both bytes. In 8-bit mode it overrides only the increment of the written byte.
- R11: The control register can be written at any time and reads back bits 6:0 as written, with bit 7 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous accumulator pin, shared with capture channel 7 |
| tick | input | 1 | Prescaled clock enable (divide-by-64) for gated mode |
| lo_evt | input | 1 | Count strobe for the low byte in 8-bit mode |
| hi_evt | input | 1 | Count strobe for the high byte in 8-bit mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pin_sync | output | 1 | Synchronised pin level for the shared capture channel |
| ovf_irq | output | 1 | Overflow interrupt |
| edge_irq | output | 1 | Edge interrupt |

## Verification
A pin level driven before clock edge k shows on `pin_sync` after edge k+1. The counter bytes, flags and interrupts it affects change after edge k+2. A `tick` or byte strobe sampled at edge k, and any register write sampled at edge k, take effect after that same edge. The bench drives inputs just after each rising edge. Its reference model takes those inputs at the next rising edge with the same latencies, and it compares read data, `pin_sync` and both interrupts at every falling edge. The read address steps on every cycle, so all four registers are compared against the model in turn.

// File: rtl/pa_pkg.sv
// Shared register addresses and control layout for the pulse accumulator.
// Assumes a 2-bit register address and a 7-bit control register.
package pa_pkg;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 7;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_FLAG   = 2'd1,
        REG_CNT_LO = 2'd2,
        REG_CNT_HI = 2'd3
    } pa_reg_e;

    // Control register, bit 0 at the bottom.
    typedef struct packed {
        logic hi_en;      // bit 6
        logic lo_en;      // bit 5
        logic edge_ie;    // bit 4
        logic ovf_ie;     // bit 3
        logic edge_pol;   // bit 2
        logic gate_mode;  // bit 1
        logic sys_en;     // bit 0
    } pa_ctrl_t;
endpackage

// File: rtl/pa_sync_edge.sv
// Multi-flop synchroniser followed by an edge detector.
// Assumes din is asynchronous. rise/fall are one-cycle pulses on sync_q changes.
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic sync_q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Shift the pin through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            prev_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], din};
            prev_q <= chain[STAGES-1];
        end
    end

    assign sync_q = chain[STAGES-1];
    assign rise   = sync_q & ~prev_q;
    assign fall   = ~sync_q & prev_q;
endmodule

// File: rtl/pa_byte_counter.sv
// One counter byte with a direct load and an increment enable.
// Assumes load takes priority over inc. full flags the all-ones value for carry.
module pa_byte_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         full
);
    // Load beats increment; otherwise count on inc.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q + 1'b1;
    end

    assign full = &q;
endmodule

// File: rtl/pa_ctrl_regs.sv
// Control register, sticky flags and read multiplexer.
// Assumes flags are write-one-to-clear and that a set in the same cycle wins.
module pa_ctrl_regs
    import pa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CTRL_W-1:0]    wr_bits,
    input  logic                 ovf_set,
    input  logic                 edge_set,
    input  logic [BYTE_W-1:0]    cnt_lo,
    input  logic [BYTE_W-1:0]    cnt_hi,
    input  logic [ADDR_W-1:0]    rd_addr,
    output pa_ctrl_t             ctrl,
    output logic                 ovf_flag,
    output logic                 edge_flag,
    output logic [BYTE_W-1:0]    rd_data
);
    logic wr_ctrl, wr_flag;

    assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    assign wr_flag = wr_en && (wr_addr == REG_FLAG);

    // Control register: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= pa_ctrl_t'(wr_bits);
    end

    // Flags: set by events, cleared by writing one, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag  <= 1'b0;
            edge_flag <= 1'b0;
        end else begin
            if (ovf_set)                 ovf_flag  <= 1'b1;
            else if (wr_flag && wr_bits[0]) ovf_flag  <= 1'b0;
            if (edge_set)                edge_flag <= 1'b1;
            else if (wr_flag && wr_bits[1]) edge_flag <= 1'b0;
        end
    end

    // Read multiplexer over the four registers.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL:   rd_data[CTRL_W-1:0] = ctrl;
            REG_FLAG:   rd_data[1:0]        = {edge_flag, ovf_flag};
            REG_CNT_LO: rd_data             = cnt_lo;
            default:    rd_data             = cnt_hi;
        endcase
    end

    AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf_flag); // R9
    AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_set |=> edge_flag); // R9
    AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && wr_bits[0] && !ovf_set) |=> !ovf_flag); // R9
endmodule

// File: rtl/pulse_accum_top.sv
// Pulse accumulator: two counter bytes that run alone or cascade to 16 bits.
// Assumes tick is a one-cycle prescaler enable and lo_evt/hi_evt are
// one-cycle strobes from the capture edge detectors.
module pulse_accum_top
    import pa_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              tick,
    input  logic              lo_evt,
    input  logic              hi_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              pin_sync,
    output logic              ovf_irq,
    output logic              edge_irq
);
    localparam int NUM_BYTES = 2;

    pa_ctrl_t               ctrl;
    logic                   edge_rise, edge_fall;
    logic                   ovf_flag, edge_flag;
    logic                   sel_edge, end_edge, gate_act, step16;
    logic                   ovf_set, edge_set;
    logic [NUM_BYTES-1:0]   byte_wr, byte_inc, byte_full, byte_evt, byte_en;
    logic [BYTE_W-1:0]      byte_q [NUM_BYTES];

    pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .sync_q (pin_sync),
        .rise   (edge_rise),
        .fall   (edge_fall)
    );

    // Qualify edges and level against the edge/level select bit.
    assign sel_edge = ctrl.edge_pol ? edge_rise : edge_fall;
    assign end_edge = ctrl.edge_pol ? edge_fall : edge_rise;
    assign gate_act = (pin_sync == ctrl.edge_pol);

    assign byte_wr[0] = wr_en && (wr_addr == REG_CNT_LO);
    assign byte_wr[1] = wr_en && (wr_addr == REG_CNT_HI);
    assign byte_evt   = {hi_evt, lo_evt};
    assign byte_en    = {ctrl.hi_en, ctrl.lo_en};

    // One 16-bit step, cancelled by any counter byte write.
    assign step16 = ctrl.sys_en && (byte_wr == '0) &&
                    (ctrl.gate_mode ? (tick && gate_act) : sel_edge);

    // Increment enables: cascaded carry in 16-bit mode, own strobes otherwise.
    always_comb begin
        byte_inc = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (ctrl.sys_en)
                byte_inc[b] = step16 && ((b == 0) || (&byte_full[b-1 >= 0 ? b-1 : 0]));
            else
                byte_inc[b] = byte_en[b] && byte_evt[b];
        end
    end

    assign ovf_set  = step16 && (&byte_full);
    assign edge_set = ctrl.sys_en && (ctrl.gate_mode ? end_edge : sel_edge);

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        pa_byte_counter #(.W(BYTE_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (byte_wr[b]),
            .load_val (wr_data[BYTE_W-1:0]),
            .inc      (byte_inc[b]),
            .q        (byte_q[b]),
            .full     (byte_full[b])
        );
    end

    pa_ctrl_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_bits   (wr_data[CTRL_W-1:0]),
        .ovf_set   (ovf_set),
        .edge_set  (edge_set),
        .cnt_lo    (byte_q[0]),
        .cnt_hi    (byte_q[1]),
        .rd_addr   (rd_addr),
        .ctrl      (ctrl),
        .ovf_flag  (ovf_flag),
        .edge_flag (edge_flag),
        .rd_data   (rd_data)
    );

    assign ovf_irq  = ovf_flag  && ctrl.ovf_ie;
    assign edge_irq = edge_flag && ctrl.edge_ie;

    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ({byte_q[1], byte_q[0]} == '0 &&
                             $past({byte_q[1], byte_q[0]}) == '1)); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr[0] |=> (byte_q[0] == $past(wr_data[BYTE_W-1:0]))); // R10
    AST_BYTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.sys_en && !ctrl.lo_en && !byte_wr[0]) |=> $stable(byte_q[0])); // R5
    AST_STROBES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sys_en && !ctrl.gate_mode && !edge_rise && !edge_fall && byte_wr == '0)
        |=> $stable({byte_q[1], byte_q[0]})); // R6
    AST_NO_EDGE_FLAG_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.sys_en && !edge_flag) |=> !edge_flag); // R8
endmodule

// File: tb/pulse_accum_top_tb_top.sv
`timescale 1ns/1ps
module pulse_accum_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0, tick = 1'b0, lo_evt = 1'b0, hi_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       pin_sync, ovf_irq, edge_irq;

    int    n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    logic  tick_run = 1'b0;
    int    tcnt = 0;

    // Reference model state.
    logic       m_s1, m_s2, m_prev;
    logic [6:0] m_ctrl;
    logic       m_ovf, m_edge;
    logic [7:0] m_lo, m_hi;

    always #2.5 clk = ~clk;

    pulse_accum_top dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick(tick),
        .lo_evt(lo_evt), .hi_evt(hi_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_sync(pin_sync), .ovf_irq(ovf_irq), .edge_irq(edge_irq)
    );

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_ctrl = 0;
            m_ovf = 0; m_edge = 0; m_lo = 0; m_hi = 0;
        end else begin
            bit rise, fall, sel, endg, wlo, whi, wfl, wct, ovs, eds, stp;
            logic [15:0] v;
            logic [7:0]  nlo, nhi;
            rise = m_s2 && !m_prev;
            fall = !m_s2 && m_prev;
            sel  = m_ctrl[2] ? rise : fall;
            endg = m_ctrl[2] ? fall : rise;
            wct  = wr_en && wr_addr == 2'd0;
            wfl  = wr_en && wr_addr == 2'd1;
            wlo  = wr_en && wr_addr == 2'd2;
            whi  = wr_en && wr_addr == 2'd3;
            nlo = m_lo; nhi = m_hi; ovs = 0; eds = 0;
            if (m_ctrl[0]) begin
                stp = m_ctrl[1] ? (tick && (m_s2 == m_ctrl[2])) : sel;
                if (stp && !wlo && !whi) begin
                    v = {m_hi, m_lo};
                    ovs = (v == 16'hFFFF);
                    v = v + 16'd1;
                    nhi = v[15:8]; nlo = v[7:0];
                end
                eds = m_ctrl[1] ? endg : sel;
            end else begin
                if (m_ctrl[5] && lo_evt) nlo = nlo + 8'd1;
                if (m_ctrl[6] && hi_evt) nhi = nhi + 8'd1;
            end
            if (wlo) nlo = wr_data;
            if (whi) nhi = wr_data;
            if (wfl && wr_data[0]) m_ovf = 0;
            if (wfl && wr_data[1]) m_edge = 0;
            if (ovs) m_ovf = 1;
            if (eds) m_edge = 1;
            if (wct) m_ctrl = wr_data[6:0];
            m_lo = nlo; m_hi = nhi;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_rd;
            case (rd_addr)
                2'd0: exp_rd = {1'b0, m_ctrl};
                2'd1: exp_rd = {6'd0, m_edge, m_ovf};
                2'd2: exp_rd = m_lo;
                default: exp_rd = m_hi;
            endcase
            chk($sformatf("rd_data[%0d]", rd_addr), rd_data, exp_rd);
            chk("pin_sync", pin_sync, m_s2);
            chk("ovf_irq", ovf_irq, m_ovf && m_ctrl[3]);
            chk("edge_irq", edge_irq, m_edge && m_ctrl[4]);
        end
    end

    // Step the read address and the tick generator just after each edge.
    always @(posedge clk) begin
        #1;
        rd_addr = rd_addr + 2'd1;
        tcnt++;
        tick = tick_run && (tcnt % 3 == 0);
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic set_pin(logic v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    task automatic toggles(int n);
        for (int i = 0; i < n; i++) begin
            set_pin(1); idle(4);
            set_pin(0); idle(4);
        end
    endtask

    task automatic strobes(int n);
        @(posedge clk); #1;
        lo_evt = 1; hi_evt = 1;
        idle(n);
        #1; lo_evt = 0; hi_evt = 0;
        idle(4);
    endtask

    initial begin
        #(5.0 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        idle(10);
        #1 rst_n = 1;
        cur_req = "R1";  idle(8);
        cur_req = "R11"; wr(0, 8'h55); idle(5); wr(0, 8'hFF); idle(5); wr(0, 8'h00); idle(4);
        cur_req = "R2";  set_pin(1); idle(4); set_pin(0); idle(4);
        cur_req = "R5";  wr(0, 8'h20); strobes(3); toggles(1);
        wr(0, 8'h40); strobes(5); wr(0, 8'h00); strobes(2);
        cur_req = "R10"; wr(2, 8'hFD); wr(3, 8'hFF); idle(4);
        cur_req = "R6";  wr(0, 8'h7D); strobes(3);
        cur_req = "R3";  toggles(2);
        cur_req = "R7";  toggles(2); idle(4);
        cur_req = "R9";  wr(1, 8'h01); idle(4); wr(1, 8'h02); idle(4);
        cur_req = "R3";  wr(0, 8'h79); toggles(3);
        cur_req = "R8";  wr(1, 8'h03); idle(2); wr(0, 8'h01); toggles(1); idle(2);
        cur_req = "R4";  wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h7F);
        tick_run = 1; set_pin(1); idle(30);
        cur_req = "R8";  set_pin(0); idle(12);
        cur_req = "R10"; set_pin(1);
        for (int i = 0; i < 6; i++) begin wr(2, 8'h10 + 8'(i)); idle(i); end
        cur_req = "R7";  wr(2, 8'hFE); wr(3, 8'hFF); idle(20);
        cur_req = "R9";
        for (int i = 0; i < 8; i++) begin
            set_pin(i % 2 == 0 ? 1'b0 : 1'b1); idle(i % 4);
            wr(1, 8'h03); idle(1);
        end
        tick_run = 0; idle(8);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule